// File: doc/BRIEF.md
# Multi-CPU System Interrupt Router

This block gathers thirty-two level-sensitive device interrupt lines into a pending register and routes them to a group of processors. A fixed lookup assigns each source line a processor interrupt level from 1 to 15. Several lines share a level. A few lines have level 0 and are dropped completely. Each line can be masked with a per-line disable bit, and the top bit of the disable register turns all routing off at once. Every surviving level goes to a single target processor chosen by software. All other processors see an all-zero level vector.

Sources at level 15 also drive a broadcast line meant for every processor. This line follows the raw source level and ignores the per-line mask, but the global disable bit still blocks it. Software works through a 32-bit word-addressed register port with these words:

- word 0: read the pending register
- word 1: read the disable register
- word 2: enable lines by clearing their mask bits
- word 3: disable lines by setting their mask bits
- word 4: read or write the target processor number

Top module: `irq_router`

## Requirements
- R1: After reset the pending register is 0, the target is processor 0, the disable register holds 0x0FA2007F (so reads of word 1 return 0), all level vectors and the broadcast line are 0, and the global-disable flag is 0.
- R2: A pending bit copies its source input on every clock. Sources whose level is 0 (bits 23 to 26 and 31) never become pending. A read of word 0 returns the pending register with bit 31 forced to 0.
- R3: Source bits 0 to 22 map to levels 2,3,5,7,9,11,13,2,3,5,7,9,11,13,12,12,6,13,4,10,8,9,11, in that order, and bits 27 to 30 map to level 15. In the target's 16-bit vector, bit L is 1 exactly when some pending, not-disabled source maps to L. Bit 0 is never set.
- R4: Writes to word 2 clear, and writes to word 3 set, only the disable bits selected by data AND 0xF05DFF80. A read of word 1 returns the disable register AND 0xF05DFF80. Bits outside that mask keep their reset value, so for example source 1 can never be routed.
- R5: Setting a source's disable bit does not change its pending bit.
- R6: A write to word 4 stores data bits 3:0 as the target number, and a read of word 4 returns it. Only the target's slice of the vector output (bits 16*t+15 down to 16*t) can be non-zero.
- R7: While disable bit 31 is 1, every level vector and the broadcast line are 0, and the global-disable output is 1.
- R8: The broadcast line is 1 when any level-15 source input (bits 27 to 30) is pending and the global bit is clear, whatever the per-line mask says.
- R9: Reads of words 5 to 7 return 0, and writes to words 0, 1 and 5 to 7 change nothing.
- R10: An input change appears in the pending register at the next clock edge and at the outputs one edge later. A register write changes the outputs on the second edge after it. Read data appears on the edge that samples the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqIn | input | 32 | Level-sensitive device interrupt sources |
| regValid | input | 1 | Register access request |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | ADDR_W (3) | Word index |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Registered read data |
| cpuLevels | output | CPU_N*16 (256) | Hard-level vector per processor, processor c in bits 16c+15:16c |
| lvl15Bcast | output | 1 | Level-15 broadcast to all processors |
| globalDisOut | output | 1 | Global-disable flag |

## Verification
A wrong entry in the level lookup or a stuck mask bit shows up as a wrong bit in the target's slice two edges after the source changes. A corrupted target register moves the whole vector to another slice at the same time. Mask bits outside the writable set cannot be read back, so the only way to see them is to raise their sources and confirm that nothing reaches the target. The bench also ties the broadcast line and the global flag to the outputs on the same edge, so a lagging copy of the global bit shows up right away.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  localparam int SRC_N  = 32;
  localparam int LVL_N  = 16;
  localparam int DATA_W = 32;
  localparam int GLOBAL_BIT = 31;

  localparam logic [DATA_W-1:0] WR_MASK   = 32'hF05D_FF80;
  localparam logic [DATA_W-1:0] DIS_RESET = 32'h0FA2_007F;

  localparam int W_PEND = 0;
  localparam int W_MASK = 1;
  localparam int W_ENA  = 2;
  localparam int W_DIS  = 3;
  localparam int W_TGT  = 4;

  typedef struct packed {
    logic enaWr;
    logic disWr;
    logic tgtWr;
    logic rdStrobe;
    logic rdPend;
    logic rdMask;
    logic rdTgt;
  } ctrlStrobe_t;

  // Processor level for each source bit; 0 means the source is dropped.
  function automatic logic [3:0] srcLevel(input int idx);
    case (idx)
      0, 7:              srcLevel = 4'd2;
      1, 8:              srcLevel = 4'd3;
      2, 9:              srcLevel = 4'd5;
      3, 10:             srcLevel = 4'd7;
      4, 11, 21:         srcLevel = 4'd9;
      5, 12, 22:         srcLevel = 4'd11;
      6, 13, 17:         srcLevel = 4'd13;
      14, 15:            srcLevel = 4'd12;
      16:                srcLevel = 4'd6;
      18:                srcLevel = 4'd4;
      19:                srcLevel = 4'd10;
      20:                srcLevel = 4'd8;
      27, 28, 29, 30:    srcLevel = 4'd15;
      default:           srcLevel = 4'd0;
    endcase
  endfunction

endpackage

// File: rtl/irq_router_ctrl.sv
module irq_router_ctrl
  import irq_router_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  output ctrlStrobe_t       strobe
);

  always_comb begin
    strobe = '0;
    if (regValid) begin
      if (regWrite) begin
        strobe.enaWr = (regAddr == ADDR_W'(W_ENA));
        strobe.disWr = (regAddr == ADDR_W'(W_DIS));
        strobe.tgtWr = (regAddr == ADDR_W'(W_TGT));
      end else begin
        strobe.rdStrobe = 1'b1;
        strobe.rdPend   = (regAddr == ADDR_W'(W_PEND));
        strobe.rdMask   = (regAddr == ADDR_W'(W_MASK));
        strobe.rdTgt    = (regAddr == ADDR_W'(W_TGT));
      end
    end
  end

endmodule

// File: rtl/irq_router_dp.sv
module irq_router_dp
  import irq_router_pkg::*;
#(
  parameter  int CPU_N = 16,
  localparam int TGT_W = (CPU_N > 1) ? $clog2(CPU_N) : 1,
  localparam int VEC_W = CPU_N * LVL_N
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SRC_N-1:0]  irqIn,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [VEC_W-1:0]  cpuLevels,
  output logic              lvl15Bcast,
  output logic              globalDisOut
);

  logic [SRC_N-1:0]  srcValid, srcTop;
  logic [SRC_N-1:0]  pendQ;
  logic [DATA_W-1:0] disQ;
  logic [TGT_W-1:0]  tgtQ;
  logic [SRC_N-1:0]  activeSrc;
  logic [LVL_N-1:0]  hardVec;
  logic              globalOff;
  logic [DATA_W-1:0] rdQ;
  logic [VEC_W-1:0]  levelsQ;
  logic              bcastQ, gdisQ;

  for (genvar i = 0; i < SRC_N; i++) begin : g_src
    assign srcValid[i] = (srcLevel(i) != 4'd0);
    assign srcTop[i]   = (srcLevel(i) == 4'(LVL_N - 1));
  end

  assign globalOff = disQ[GLOBAL_BIT];
  assign activeSrc = globalOff ? '0 : (pendQ & ~disQ);

  always_comb begin
    hardVec = '0;
    for (int i = 0; i < SRC_N; i++) begin
      if (activeSrc[i]) hardVec[srcLevel(i)] = 1'b1;
    end
    hardVec[0] = 1'b0;
  end

  // State registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ <= '0;
      disQ  <= DIS_RESET;
      tgtQ  <= '0;
    end else begin
      pendQ <= irqIn & srcValid;
      if (strobe.enaWr)      disQ <= disQ & ~(wrData & WR_MASK);
      else if (strobe.disWr) disQ <= disQ | (wrData & WR_MASK);
      if (strobe.tgtWr)      tgtQ <= wrData[TGT_W-1:0];
    end
  end

  // Read data
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdQ <= '0;
    end else if (strobe.rdStrobe) begin
      if (strobe.rdPend)      rdQ <= pendQ & ~(DATA_W'(1) << GLOBAL_BIT);
      else if (strobe.rdMask) rdQ <= disQ & WR_MASK;
      else if (strobe.rdTgt)  rdQ <= DATA_W'(tgtQ);
      else                    rdQ <= '0;
    end
  end

  // Registered outputs, one slice per processor
  for (genvar c = 0; c < CPU_N; c++) begin : g_cpu
    always_ff @(posedge clk) begin
      if (!rstN) levelsQ[c*LVL_N +: LVL_N] <= '0;
      else       levelsQ[c*LVL_N +: LVL_N] <= (tgtQ == TGT_W'(c)) ? hardVec : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bcastQ <= 1'b0;
      gdisQ  <= 1'b0;
    end else begin
      bcastQ <= (|(pendQ & srcTop)) & ~globalOff;
      gdisQ  <= globalOff;
    end
  end

  assign rdData       = rdQ;
  assign cpuLevels    = levelsQ;
  assign lvl15Bcast   = bcastQ;
  assign globalDisOut = gdisQ;

endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter  int CPU_N  = 16,
  parameter  int ADDR_W = 3,
  localparam int VEC_W  = CPU_N * LVL_N
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SRC_N-1:0]  irqIn,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic [VEC_W-1:0]  cpuLevels,
  output logic              lvl15Bcast,
  output logic              globalDisOut
);

  ctrlStrobe_t strobe;

  irq_router_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regValid (regValid),
    .regWrite (regWrite),
    .regAddr  (regAddr),
    .strobe   (strobe)
  );

  irq_router_dp #(.CPU_N(CPU_N)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .irqIn        (irqIn),
    .strobe       (strobe),
    .wrData       (regWdata),
    .rdData       (regRdata),
    .cpuLevels    (cpuLevels),
    .lvl15Bcast   (lvl15Bcast),
    .globalDisOut (globalDisOut)
  );

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
  import irq_router_pkg::*;
#(
  parameter  int CPU_N  = 16,
  parameter  int ADDR_W = 3,
  localparam int TGT_W  = (CPU_N > 1) ? $clog2(CPU_N) : 1,
  localparam int VEC_W  = CPU_N * LVL_N
) (
  input logic              clk,
  input logic              rstN,
  input logic              regValid,
  input logic              regWrite,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regRdata,
  input logic [VEC_W-1:0]  cpuLevels,
  input logic              lvl15Bcast,
  input logic              globalDisOut
);

  logic [CPU_N-1:0] cpuBusy, cpuBit0;
  for (genvar c = 0; c < CPU_N; c++) begin : g_c
    assign cpuBusy[c] = |cpuLevels[c*LVL_N +: LVL_N];
    assign cpuBit0[c] = cpuLevels[c*LVL_N];
  end

  logic rdReq;
  assign rdReq = regValid && !regWrite;

  a_r6_single_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(cpuBusy));

  a_r3_no_level_zero: assert property (@(posedge clk) disable iff (!rstN)
    cpuBit0 == '0);

  a_r7_global_quiet: assert property (@(posedge clk) disable iff (!rstN)
    globalDisOut |-> (cpuBusy == '0 && !lvl15Bcast));

  a_r2_pend_read_clean: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && regAddr == ADDR_W'(W_PEND)) |=> (regRdata[31] == 1'b0 && regRdata[26:23] == 4'd0));

  a_r4_mask_read: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && regAddr == ADDR_W'(W_MASK)) |=> ((regRdata & ~WR_MASK) == '0));

  a_r6_target_read: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && regAddr == ADDR_W'(W_TGT)) |=> (regRdata[DATA_W-1:TGT_W] == '0));

  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && regAddr > ADDR_W'(W_TGT)) |=> (regRdata == '0));

endmodule

bind irq_router irq_router_chk #(.CPU_N(CPU_N), .ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .regValid     (regValid),
  .regWrite     (regWrite),
  .regAddr      (regAddr),
  .regRdata     (regRdata),
  .cpuLevels    (cpuLevels),
  .lvl15Bcast   (lvl15Bcast),
  .globalDisOut (globalDisOut)
);

// File: tb/test_irq_router.sv
module test_irq_router;

  localparam int CPU_N = 16;
  localparam int VW    = CPU_N * 16;
  localparam logic [31:0] WM = 32'hF05D_FF80;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [31:0]   irqIn = '0;
  logic          regValid = 1'b0;
  logic          regWrite = 1'b0;
  logic [2:0]    regAddr = '0;
  logic [31:0]   regWdata = '0;
  logic [31:0]   regRdata;
  logic [VW-1:0] cpuLevels;
  logic          lvl15Bcast, globalDisOut;

  always #2 clk = ~clk;

  irq_router #(.CPU_N(CPU_N), .ADDR_W(3)) i_irq_router (
    .clk(clk), .rstN(rstN), .irqIn(irqIn),
    .regValid(regValid), .regWrite(regWrite), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata),
    .cpuLevels(cpuLevels), .lvl15Bcast(lvl15Bcast), .globalDisOut(globalDisOut)
  );

  // Level table from the requirements
  int lvlTab [32] = '{2,3,5,7,9,11,13,2,3,5,7,9,11,13,12,12,
                      6,13,4,10,8,9,11,0,0,0,0,15,15,15,15,0};

  // Reference state
  logic [31:0] mPend = '0;
  logic [31:0] mDis  = 32'h0FA2_007F;
  logic [3:0]  mTgt  = '0;

  typedef struct { string req; int kind; logic [VW-1:0] exp; } sbItem_t;
  sbItem_t sbQ[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  function automatic logic [31:0] validMask();
    logic [31:0] m = '0;
    for (int i = 0; i < 32; i++) m[i] = (lvlTab[i] != 0);
    return m;
  endfunction

  function automatic logic [VW-1:0] expLevels();
    logic [15:0] hv = '0;
    logic [31:0] act;
    logic [VW-1:0] r = '0;
    act = mDis[31] ? 32'h0 : (mPend & ~mDis);
    for (int i = 0; i < 32; i++) if (act[i] && lvlTab[i] != 0) hv[lvlTab[i]] = 1'b1;
    r[mTgt*16 +: 16] = hv;
    return r;
  endfunction

  function automatic logic expBcast();
    logic any = 1'b0;
    for (int i = 0; i < 32; i++) if (mPend[i] && lvlTab[i] == 15) any = 1'b1;
    return any && !mDis[31];
  endfunction

  // Monitor: compare queued expectations away from the clock edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sbQ.size() > 0) begin
        sbItem_t it;
        logic [VW-1:0] act;
        it = sbQ.pop_front();
        case (it.kind)
          0: act = VW'(regRdata);
          1: act = cpuLevels;
          2: act = VW'(lvl15Bcast);
          default: act = VW'(globalDisOut);
        endcase
        checks++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s kind%0d: actual %h expected %h", it.req, it.kind, act, it.exp);
        end
      end
    end
  end

  task automatic push(string req, int kind, logic [VW-1:0] e);
    sbItem_t it;
    it.req = req; it.kind = kind; it.exp = e;
    sbQ.push_back(it);
  endtask

  task automatic pushOuts(string req);
    push(req, 1, expLevels());
    push(req, 2, VW'(expBcast()));
    push(req, 3, VW'(mDis[31]));
  endtask

  task automatic stepN(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setIrq(logic [31:0] v);
    irqIn = v;
    mPend = v & validMask();
    stepN(2);
  endtask

  task automatic wrReg(logic [2:0] a, logic [31:0] d);
    regValid = 1'b1; regWrite = 1'b1; regAddr = a; regWdata = d;
    stepN(1);
    regValid = 1'b0; regWrite = 1'b0;
    case (a)
      3'd2: mDis = mDis & ~(d & WM);
      3'd3: mDis = mDis | (d & WM);
      3'd4: mTgt = d[3:0];
      default: ;
    endcase
    stepN(1);
  endtask

  task automatic rdReg(logic [2:0] a, logic [31:0] e, string req);
    regValid = 1'b1; regWrite = 1'b0; regAddr = a;
    stepN(1);
    regValid = 1'b0;
    push(req, 0, VW'(e));
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL R10 watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    stepN(3);
    rstN = 1'b1;
    // R1: reset state
    pushOuts("R1");
    stepN(1);
    rdReg(3'd0, 32'h0, "R1");
    rdReg(3'd1, 32'h0, "R1");
    rdReg(3'd4, 32'h0, "R1");

    // R10: input reaches the outputs on the second edge
    irqIn = 32'h0000_0800;
    stepN(1);
    push("R10", 1, '0);
    mPend = irqIn & validMask();
    stepN(1);
    pushOuts("R10");
    rdReg(3'd0, 32'h0000_0800, "R10");

    // R3: level mapping under several patterns
    setIrq(32'h0000_0080); pushOuts("R3");
    setIrq(32'h0001_0000); pushOuts("R3");
    setIrq(32'h0000_C000); pushOuts("R3");
    setIrq(32'h0050_0000); pushOuts("R3");
    setIrq(32'h0004_1F80); pushOuts("R3");

    // R2: level-0 sources never pend, bit 31 reads 0
    setIrq(32'h8780_0200); pushOuts("R2");
    rdReg(3'd0, mPend, "R2");

    // R4: write mask; source 1 stays blocked
    setIrq(32'h0000_0002); pushOuts("R4");
    wrReg(3'd2, 32'hFFFF_FFFF); pushOuts("R4");
    rdReg(3'd1, mDis & WM, "R4");
    wrReg(3'd3, 32'hFFFF_FFFF);
    rdReg(3'd1, 32'hF05D_FF80, "R4");
    // R7: global disable set
    pushOuts("R7");
    wrReg(3'd2, 32'h8000_0000); pushOuts("R7");
    rdReg(3'd1, 32'h705D_FF80, "R4");

    // R5: disabled source keeps its pending bit
    setIrq(32'h0000_0200); pushOuts("R5");
    rdReg(3'd0, 32'h0000_0200, "R5");
    wrReg(3'd2, 32'h0000_0200); pushOuts("R5");

    // R6: retarget to processor 5 (upper data bits dropped)
    wrReg(3'd4, 32'hFFFF_FF35); pushOuts("R6");
    rdReg(3'd4, 32'h5, "R6");

    // R8: level-15 broadcast ignores the per-line mask
    setIrq(32'h0800_0200); pushOuts("R8");
    setIrq(32'h1000_0200); pushOuts("R8");
    wrReg(3'd2, 32'h1000_0000); pushOuts("R8");
    wrReg(3'd3, 32'h8000_0000); pushOuts("R7");
    rdReg(3'd0, 32'h1000_0200, "R7");
    wrReg(3'd2, 32'h8000_0000); pushOuts("R8");

    // R9: unmapped and read-only words
    for (int a = 5; a < 8; a++) wrReg(3'(a), 32'hFFFF_FFFF);
    wrReg(3'd0, 32'hFFFF_FFFF);
    wrReg(3'd1, 32'h0000_0000);
    pushOuts("R9");
    for (int a = 5; a < 8; a++) rdReg(3'(a), 32'h0, "R9");
    rdReg(3'd1, mDis & WM, "R9");
    rdReg(3'd4, 32'h5, "R9");

    stepN(3);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule